// File: doc/BRIEF.md
# Ready-Triggered Register Burst Reader

This block is an SPI master sequencer for a multichannel SAR converter that accumulates its results in on-chip registers. When the converter signals end of conversion on one of four general-purpose pins, the block reads the 16-bit result register of every enabled channel in one burst, lowest channel first. Each read is a 32-bit frame that carries a two-byte register address with a read flag. The burst ends with a write to the converter's state-reset register, which re-arms the ready signal for the next conversion.

Each captured result leaves the block as a 32-bit word on a valid/ready stream, with the 16-bit value in the lower half. The stream is meant to feed a DMA engine. Register addresses come from a base and a stride that are set at elaboration. The SCLK rate, the minimum chip-select high time and the reset register address and value are also elaboration parameters. A hold input stops new bursts from starting, but a burst that is already running completes.

Top module: `rdy_burst_reader`

## Requirements
- R1: After synchronous reset, chip-select is high, SCLK is low, MOSI is low, the output stream is not valid and the overrun flag is clear.
- R2: Every transfer is one 32-bit frame. It is shifted MSB first with SCLK idle low. MOSI changes after falling edges and MISO is sampled on rising edges. SCLK stays low whenever chip-select is high.
- R3: The read frame for channel c is {A[15:8] | 0x80, A[7:0], 0x00, 0x00}, with A = BASE_ADDR + ADDR_STRIDE * c. With the defaults, A = 0x0201 + 2c.
- R4: A burst sends one read frame per set bit of the channel mask, in ascending channel order, and then exactly one reset frame. An all-zero mask gives only the reset frame.
- R5: Each read frame produces exactly one output word {16'h0000, last two received bytes}. The reset frame produces no output word.
- R6: Chip-select is released between consecutive read frames and stays high for at least CS_HIGH_MIN clock cycles. It stays low from the last read frame through the reset frame, so a burst with n reads has max(n,1) chip-select assertions.
- R7: The reset frame is {RESET_ADDR[15:8], RESET_ADDR[7:0], RESET_VALUE, 0x00}, which is {0x01, 0x80, 0x01, 0x00} with the defaults.
- R8: A burst starts on a rising edge of gp_rdy_i[rdy_sel_i] only. Edges on the other three pins have no effect.
- R9: A ready edge on the selected pin during a burst, including its trailing chip-select high time, starts nothing and sets overrun_o. overrun_o then stays set until reset.
- R10: While hold_i is high, a ready edge starts no burst and does not set overrun_o. A burst already under way runs to completion.
- R11: While m_valid_o is high and m_ready_i is low, m_data_o stays unchanged and m_valid_o stays high. The sequencer stalls, so no result is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Blocks new bursts while high |
| ch_mask_i | input | NUM_CH | Channel enable mask, bit c enables channel c |
| rdy_sel_i | input | 2 | Index of the ready pin that starts bursts |
| gp_rdy_i | input | 4 | Ready candidates from the converter's general-purpose pins |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_cs_n_o | output | 1 | SPI chip-select, active low |
| spi_mosi_o | output | 1 | SPI data to converter |
| spi_miso_i | input | 1 | SPI data from converter |
| m_data_o | output | 32 | Result word, value in bits 15:0 |
| m_valid_o | output | 1 | Result word valid |
| m_ready_i | input | 1 | Downstream accepts the word |
| overrun_o | output | 1 | Sticky flag for ready edges seen during a burst |

## Verification
The chip-select gap and SCLK-idle properties assume that ch_mask_i and rdy_sel_i change only while the block is idle. A pin or mask change in the middle of a burst could otherwise create a false ready edge or change the frame order. The bench changes both only between bursts, after chip-select has been high for long stretches. The output-stability property assumes nothing about m_ready_i, so the stimulus applies long stall windows, longer than one frame, to force the sequencer to wait with a result pending.

// File: rtl/rdy_burst_pkg.sv
package rdy_burst_pkg;

    localparam int FRAME_BITS  = 32;
    localparam int RESULT_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PUSH,
        ST_GAP,
        ST_RESET,
        ST_TAIL
    } seq_state_e;

    // Byte b0 goes out on the wire first.
    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] b3;
    } frame_t;

    function automatic logic [15:0] chan_addr(input logic [15:0] base,
                                              input logic [15:0] stride,
                                              input logic [7:0]  idx);
        logic [15:0] ofs;
        ofs = stride * {8'h00, idx};
        return base + ofs;
    endfunction

    function automatic frame_t make_read(input logic [15:0] addr);
        frame_t f;
        f.b0 = addr[15:8] | 8'h80;
        f.b1 = addr[7:0];
        f.b2 = 8'h00;
        f.b3 = 8'h00;
        return f;
    endfunction

    function automatic frame_t make_write(input logic [15:0] addr,
                                          input logic [7:0]  val);
        frame_t f;
        f.b0 = addr[15:8];
        f.b1 = addr[7:0];
        f.b2 = val;
        f.b3 = 8'h00;
        return f;
    endfunction

    function automatic logic [31:0] fmt_result(input logic [31:0] rx);
        return {{(FRAME_BITS-RESULT_BITS){1'b0}}, rx[RESULT_BITS-1:0]};
    endfunction

endpackage

// File: rtl/rdy_trig_detect.sv
module rdy_trig_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_PINS    = 4,
    localparam int SEL_W      = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                rise_o
);
    logic [NUM_PINS-1:0] synced;
    logic                sel_now;
    logic                prev_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[SYNC_STAGES-2:0], pins_i[p]};
        end
        assign synced[p] = chain_q[SYNC_STAGES-1];
    end

    assign sel_now = synced[sel_i];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sel_now;
    end

    assign rise_o = sel_now & ~prev_q;
endmodule

// File: rtl/rdy_chan_pick.sv
module rdy_chan_pick #(
    parameter int NUM_CH = 16,
    parameter int IDX_W  = 5
) (
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [IDX_W-1:0]  from_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [NUM_CH-1:0] elig;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_elig
        assign elig[g] = mask_i[g] && (IDX_W'(g) >= from_i);
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rdy_frame_shifter.sv
module rdy_frame_shifter import rdy_burst_pkg::*; #(
    parameter int SCLK_DIV = 2,
    localparam int DIV_W   = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1,
    localparam int BIT_W   = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] tx_i,
    input  logic                  miso_i,
    output logic                  sclk_o,
    output logic                  mosi_o,
    output logic [FRAME_BITS-1:0] rx_o,
    output logic                  done_o
);
    logic [DIV_W-1:0]      div_q;
    logic [BIT_W-1:0]      bit_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic                  sclk_q;
    logic                  busy_q;
    logic                  done_q;
    logic                  tick;

    assign tick = busy_q && (div_q == DIV_W'(SCLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                busy_q <= 1'b1;
                tx_q   <= tx_i;
                bit_q  <= '0;
                div_q  <= '0;
                sclk_q <= 1'b0;
            end else if (busy_q) begin
                div_q <= tick ? '0 : div_q + 1'b1;
                if (tick) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[FRAME_BITS-2:0], miso_i};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = busy_q & tx_q[FRAME_BITS-1];
    assign rx_o   = rx_q;
    assign done_o = done_q;
endmodule

// File: rtl/rdy_burst_reader.sv
module rdy_burst_reader import rdy_burst_pkg::*; #(
    parameter int          NUM_CH      = 16,
    parameter logic [15:0] BASE_ADDR   = 16'h0201,
    parameter logic [15:0] ADDR_STRIDE = 16'h0002,
    parameter logic [15:0] RESET_ADDR  = 16'h0180,
    parameter logic [7:0]  RESET_VALUE = 8'h01,
    parameter int          SCLK_DIV    = 2,
    parameter int          CS_HIGH_MIN = 3,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic [NUM_CH-1:0] ch_mask_i,
    input  logic [1:0]        rdy_sel_i,
    input  logic [3:0]        gp_rdy_i,
    output logic              spi_sclk_o,
    output logic              spi_cs_n_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i,
    output logic [31:0]       m_data_o,
    output logic              m_valid_o,
    input  logic              m_ready_i,
    output logic              overrun_o
);
    localparam int IDX_W = $clog2(NUM_CH) + 1;
    localparam int GAP_W = $clog2(CS_HIGH_MIN + 1);

    seq_state_e            state_q;
    logic [IDX_W-1:0]      cur_q;
    logic [IDX_W-1:0]      pick_from;
    logic [IDX_W-1:0]      pick_idx;
    logic [IDX_W-1:0]      rd_idx;
    logic                  pick_found;
    logic [GAP_W-1:0]      gap_q;
    logic                  gap_done;
    logic                  cs_n_q;
    logic                  overrun_q;
    logic                  out_valid_q;
    logic [31:0]           out_data_q;
    logic [31:0]           rx_hold_q;
    logic                  trig;
    logic                  sh_start;
    logic                  sh_done;
    logic [FRAME_BITS-1:0] sh_tx;
    logic [FRAME_BITS-1:0] sh_rx;
    logic                  slot_free;
    frame_t                reset_frame;
    frame_t                read_frame;

    rdy_trig_detect #(.SYNC_STAGES(SYNC_STAGES), .NUM_PINS(4)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .pins_i (gp_rdy_i),
        .sel_i  (rdy_sel_i),
        .rise_o (trig)
    );

    assign pick_from = (state_q == ST_IDLE) ? '0 : cur_q + IDX_W'(1);

    rdy_chan_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .mask_i  (ch_mask_i),
        .from_i  (pick_from),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    rdy_frame_shifter #(.SCLK_DIV(SCLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start_i (sh_start),
        .tx_i    (sh_tx),
        .miso_i  (spi_miso_i),
        .sclk_o  (spi_sclk_o),
        .mosi_o  (spi_mosi_o),
        .rx_o    (sh_rx),
        .done_o  (sh_done)
    );

    assign rd_idx      = (state_q == ST_GAP) ? cur_q : pick_idx;
    assign read_frame  = make_read(chan_addr(BASE_ADDR, ADDR_STRIDE, 8'(rd_idx)));
    assign reset_frame = make_write(RESET_ADDR, RESET_VALUE);
    assign gap_done    = (gap_q == GAP_W'(CS_HIGH_MIN - 1));
    assign slot_free   = !out_valid_q || m_ready_i;

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = reset_frame;
        case (state_q)
            ST_IDLE: begin
                if (trig && !hold_i) begin
                    sh_start = 1'b1;
                    sh_tx    = pick_found ? read_frame : reset_frame;
                end
            end
            ST_PUSH: begin
                if (slot_free && !pick_found) sh_start = 1'b1;
            end
            ST_GAP: begin
                if (gap_done) begin
                    sh_start = 1'b1;
                    sh_tx    = read_frame;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_q       <= '0;
            gap_q       <= '0;
            cs_n_q      <= 1'b1;
            overrun_q   <= 1'b0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            rx_hold_q   <= '0;
        end else begin
            if (out_valid_q && m_ready_i) out_valid_q <= 1'b0;
            if (trig && state_q != ST_IDLE) overrun_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (trig && !hold_i) begin
                        cs_n_q <= 1'b0;
                        if (pick_found) begin
                            cur_q   <= pick_idx;
                            state_q <= ST_READ;
                        end else begin
                            state_q <= ST_RESET;
                        end
                    end
                end
                ST_READ: begin
                    if (sh_done) begin
                        rx_hold_q <= sh_rx;
                        state_q   <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (slot_free) begin
                        out_data_q  <= fmt_result(rx_hold_q);
                        out_valid_q <= 1'b1;
                        if (pick_found) begin
                            cur_q   <= pick_idx;
                            cs_n_q  <= 1'b1;
                            gap_q   <= '0;
                            state_q <= ST_GAP;
                        end else begin
                            state_q <= ST_RESET;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        cs_n_q  <= 1'b0;
                        state_q <= ST_READ;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_RESET: begin
                    if (sh_done) begin
                        cs_n_q  <= 1'b1;
                        gap_q   <= '0;
                        state_q <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (gap_done) state_q <= ST_IDLE;
                    else          gap_q   <= gap_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign spi_cs_n_o = cs_n_q;
    assign m_data_o   = out_data_q;
    assign m_valid_o  = out_valid_q;
    assign overrun_o  = overrun_q;
endmodule

// File: rtl/rdy_burst_reader_chk.sv
module rdy_burst_reader_chk #(
    parameter int CS_HIGH_MIN = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        sclk,
    input logic [31:0] out_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic        overrun
);
    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)       hi_cnt <= CS_HIGH_MIN;
        else if (!cs_n) hi_cnt <= 0;
        else if (hi_cnt < CS_HIGH_MIN) hi_cnt <= hi_cnt + 1;
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[31:16] == 16'h0000));

    assert_cs_gap_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_cnt >= CS_HIGH_MIN));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind rdy_burst_reader rdy_burst_reader_chk #(.CS_HIGH_MIN(CS_HIGH_MIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (spi_cs_n_o),
    .sclk      (spi_sclk_o),
    .out_data  (m_data_o),
    .out_valid (m_valid_o),
    .out_ready (m_ready_i),
    .overrun   (overrun_o)
);

// File: tb/rdy_burst_reader_bench.sv
module rdy_burst_reader_bench;
    localparam int          NCH     = 16;
    localparam logic [15:0] BASE    = 16'h0201;
    localparam logic [15:0] STRIDE  = 16'h0002;
    localparam logic [15:0] RST_A   = 16'h0180;
    localparam logic [7:0]  RST_V   = 8'h01;
    localparam int          CS_MIN  = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst = 1'b1;
    logic           hold = 1'b0;
    logic [NCH-1:0] mask = '0;
    logic [1:0]     sel = 2'd0;
    logic [3:0]     gp = 4'h0;
    logic           miso = 1'b0;
    logic           mready = 1'b1;
    wire            sclk, cs_n, mosi, mvalid, ovr;
    wire [31:0]     mdata;

    rdy_burst_reader #(
        .NUM_CH(NCH), .BASE_ADDR(BASE), .ADDR_STRIDE(STRIDE),
        .RESET_ADDR(RST_A), .RESET_VALUE(RST_V), .SCLK_DIV(2),
        .CS_HIGH_MIN(CS_MIN), .SYNC_STAGES(2)
    ) u_rdy_burst_reader (
        .clk(clk), .rst(rst), .hold_i(hold), .ch_mask_i(mask),
        .rdy_sel_i(sel), .gp_rdy_i(gp), .spi_sclk_o(sclk),
        .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
        .m_data_o(mdata), .m_valid_o(mvalid), .m_ready_i(mready),
        .overrun_o(ovr)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    function automatic logic [15:0] model_data(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] exp_addr(input int ch);
        return BASE + STRIDE * 16'(ch);
    endfunction

    function automatic logic [31:0] exp_read(input int ch);
        logic [15:0] a;
        a = exp_addr(ch);
        return {a[15:8] | 8'h80, a[7:0], 16'h0000};
    endfunction

    // converter model
    logic [31:0] frames [256];
    int          nframes = 0;
    int          bitn = 0;
    logic [31:0] rxs = '0;
    logic [15:0] resp = '0;
    logic        m_prev_cs = 1'b1;
    logic        m_prev_sclk = 1'b0;

    always @(sclk, cs_n) begin
        if (cs_n === 1'b0 && m_prev_cs === 1'b1) begin
            bitn = 0;
            miso = 1'b0;
        end else if (cs_n === 1'b0 && sclk === 1'b1 && m_prev_sclk === 1'b0) begin
            rxs  = {rxs[30:0], mosi};
            bitn = bitn + 1;
            if (bitn == 32) begin
                if (nframes < 256) frames[nframes] = rxs;
                nframes = nframes + 1;
                bitn = 0;
            end
        end else if (cs_n === 1'b0 && sclk === 1'b0 && m_prev_sclk === 1'b1) begin
            if (bitn == 16) resp = model_data(rxs[15:0] & 16'h7FFF);
            if (bitn >= 16) miso = resp[31 - bitn];
            else            miso = 1'b0;
        end
        m_prev_cs   = cs_n;
        m_prev_sclk = sclk;
    end

    // stream sink, chip-select monitor, watchdog
    logic [31:0] words [256];
    int          nwords = 0;
    int          gaps [256];
    int          ngaps = 0;
    int          cs_falls = 0;
    int          hi_run = 0;
    logic        mon_prev_cs = 1'b1;
    int          rdy_mode = 0;
    logic        stall_pend = 1'b0;
    logic [31:0] stall_data = '0;
    int          stall_err = 0;
    logic        r;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (mon_prev_cs === 1'b1 && cs_n === 1'b0) begin
                if (ngaps < 256) gaps[ngaps] = hi_run;
                ngaps    = ngaps + 1;
                cs_falls = cs_falls + 1;
            end
            if (cs_n === 1'b1) hi_run = hi_run + 1;
            else               hi_run = 0;
            mon_prev_cs = cs_n;
            r = (rdy_mode == 0) ? 1'b1 : ((cyc % 400) >= 360);
            if (stall_pend && (!mvalid || mdata !== stall_data)) stall_err = stall_err + 1;
            stall_pend = mvalid && !r;
            stall_data = mdata;
            mready = r;
            if (mvalid && r) begin
                if (nwords < 256) words[nwords] = mdata;
                nwords = nwords + 1;
            end
        end
        if (cyc > 190000) begin
            $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 190000)", cyc);
            fails = fails + 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input int pin);
        @(negedge clk) gp[pin] = 1'b1;
        repeat (3) @(negedge clk);
        gp[pin] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_done(input int ef, input int ew);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (nframes >= ef && nwords >= ew) break;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic verify(input logic [NCH-1:0] m, input int fb, input int wb,
                          input int gb, input int cb);
        int n;
        int k;
        int mg;
        n = $countones(m);
        k = 0;
        check(nframes - fb == n + 1, "R4", "frame count", 32'(nframes - fb), 32'(n + 1));
        for (int ch = 0; ch < NCH; ch++) begin
            if (m[ch]) begin
                check(frames[fb+k] == exp_read(ch), "R3", "read frame", frames[fb+k], exp_read(ch));
                check(words[wb+k] == {16'h0000, model_data(exp_addr(ch))}, "R5", "result word",
                      words[wb+k], {16'h0000, model_data(exp_addr(ch))});
                k++;
            end
        end
        check(frames[fb+n] == {RST_A, RST_V, 8'h00}, "R7", "reset frame",
              frames[fb+n], {RST_A, RST_V, 8'h00});
        check(nwords - wb == n, "R5", "word count", 32'(nwords - wb), 32'(n));
        check(cs_falls - cb == ((n == 0) ? 1 : n), "R6", "chip-select assertions",
              32'(cs_falls - cb), 32'((n == 0) ? 1 : n));
        if (n > 1) begin
            mg = 1000000;
            for (int i = gb + 1; i < ngaps; i++) if (gaps[i] < mg) mg = gaps[i];
            check(mg >= CS_MIN, "R6", "min chip-select high", 32'(mg), 32'(CS_MIN));
        end
    endtask

    task automatic run_burst(input logic [NCH-1:0] m, input logic [1:0] s);
        int fb, wb, gb, cb;
        mask = m;
        sel  = s;
        repeat (4) @(negedge clk);
        fb = nframes; wb = nwords; gb = ngaps; cb = cs_falls;
        pulse(s);
        wait_done(fb + $countones(m) + 1, wb + $countones(m));
        verify(m, fb, wb, gb, cb);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(cs_n == 1'b1, "R1", "cs_n after reset", 32'(cs_n), 32'd1);
        check(sclk == 1'b0, "R1", "sclk after reset", 32'(sclk), 32'd0);
        check(mosi == 1'b0, "R1", "mosi after reset", 32'(mosi), 32'd0);
        check(mvalid == 1'b0, "R1", "valid after reset", 32'(mvalid), 32'd0);
        check(ovr == 1'b0, "R1", "overrun after reset", 32'(ovr), 32'd0);
    endtask

    task automatic t_single();
        run_burst(16'h0001, 2'd0);
        check(ovr == 1'b0, "R9", "overrun after clean burst", 32'(ovr), 32'd0);
    endtask

    task automatic t_sparse();
        run_burst(16'hA5A2, 2'd2);
    endtask

    task automatic t_full_backpressure();
        rdy_mode = 1;
        run_burst(16'hFFFF, 2'd3);
        rdy_mode = 0;
        check(stall_err == 0, "R11", "word changed during stall", 32'(stall_err), 32'd0);
    endtask

    task automatic t_empty_mask();
        run_burst(16'h0000, 2'd1);
    endtask

    task automatic t_other_pins();
        int fb, cb;
        mask = 16'h00F0;
        sel  = 2'd1;
        repeat (4) @(negedge clk);
        fb = nframes; cb = cs_falls;
        pulse(0);
        pulse(3);
        pulse(2);
        repeat (400) @(negedge clk);
        check(nframes == fb, "R8", "frames from unselected pins", 32'(nframes - fb), 32'd0);
        check(cs_falls == cb, "R8", "cs activity from unselected pins", 32'(cs_falls - cb), 32'd0);
        run_burst(16'h00F0, 2'd1);
    endtask

    task automatic t_hold();
        int fb, wb, gb, cb;
        mask = 16'h0003;
        sel  = 2'd0;
        hold = 1'b1;
        repeat (4) @(negedge clk);
        fb = nframes; cb = cs_falls;
        pulse(0);
        repeat (400) @(negedge clk);
        check(nframes == fb, "R10", "frames while held", 32'(nframes - fb), 32'd0);
        check(cs_falls == cb, "R10", "cs activity while held", 32'(cs_falls - cb), 32'd0);
        check(ovr == 1'b0, "R10", "overrun from held edge", 32'(ovr), 32'd0);
        hold = 1'b0;
        repeat (4) @(negedge clk);
        fb = nframes; wb = nwords; gb = ngaps; cb = cs_falls;
        pulse(0);
        repeat (100) @(negedge clk);
        hold = 1'b1;
        wait_done(fb + 3, wb + 2);
        verify(16'h0003, fb, wb, gb, cb);
        hold = 1'b0;
    endtask

    task automatic t_overrun();
        int fb, wb, gb, cb;
        mask = 16'h0101;
        sel  = 2'd0;
        repeat (4) @(negedge clk);
        fb = nframes; wb = nwords; gb = ngaps; cb = cs_falls;
        pulse(0);
        repeat (150) @(negedge clk);
        pulse(0);
        wait_done(fb + 3, wb + 2);
        repeat (600) @(negedge clk);
        verify(16'h0101, fb, wb, gb, cb);
        check(ovr == 1'b1, "R9", "overrun flag", 32'(ovr), 32'd1);
        repeat (50) @(negedge clk);
        check(ovr == 1'b1, "R9", "overrun stays set", 32'(ovr), 32'd1);
        do_reset();
        check(ovr == 1'b0, "R1", "overrun cleared by reset", 32'(ovr), 32'd0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_sparse();
        t_full_backpressure();
        t_empty_mask();
        t_other_pins();
        t_hold();
        t_overrun();
        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule